// File: doc/BRIEF.md
# Ping-Pong Receive Buffer with Destination Filter

This block receives Ethernet frames as a byte stream, qualified by a valid strobe with first and last markers. It filters each frame on its destination address and stores it in one of two receive buffers. Each buffer has a control word that software reads and writes through a small register port. When a frame is accepted and stored, the block sets the buffer's full flag and may raise a one-cycle interrupt. If alternation is enabled, it then switches to the other buffer for the next frame.

Software takes ownership of a full buffer and reads its contents. It hands the buffer back by writing the full flag to zero. A frame that arrives while the selected buffer is still full is lost. Nothing is written for a lost frame, so the data software is reading stays intact. Frame check sequence handling and the line interface belong to neighbouring blocks.

Top module: `pingpong_rx_buffer`

## Requirements
- R1: After reset both control words read 0, `rx_irq` is low, and the first frame goes to buffer 0.
- R2: A frame whose first byte has bit 7 set (group address) is accepted, whatever the station address is.
- R3: A frame whose first byte has bit 7 clear is accepted only when its first six bytes equal `station_mac`, with byte 0 compared to `station_mac[47:40]` and byte 5 to `station_mac[7:0]`. Any other frame, including one shorter than six bytes, leaves the full flags, the buffer selection and `rx_irq` unchanged.
- R4: Byte i of a stored frame sits in data word i/4 of its buffer, in bits [8*(i%4)+7 : 8*(i%4)]. Buffer 0 data starts at window offset 0x000 and buffer 1 data starts at 0x800.
- R5: After an accepted frame is stored, bit 0 (full) of that buffer's control word reads 1.
- R6: A frame that starts while the selected buffer's full bit is 1 is lost. It writes no byte, changes no full flag, raises no interrupt and does not change the selection.
- R7: `rx_irq` is high for the single cycle after the last byte of an accepted frame, and only when bit 3 of buffer 0's control word and `irq_master_en` are both 1. This gating applies to frames stored in either buffer.
- R8: With `cfg_pingpong` = 1 the selected buffer alternates after each stored frame. With `cfg_pingpong` = 0 every frame uses buffer 0.
- R9: Control words sit at window offsets 0x7FC (buffer 0) and 0xFFC (buffer 1). A write stores bit 0 (full) and bit 3 (interrupt enable), and all other bits read as 0. Writing bit 0 as 0 releases the buffer.
- R10: Bytes beyond the 2036-byte data area are not stored. A frame longer than that is still marked full when accepted.
- R11: Bytes of a rejected frame may overwrite the current buffer's data. They never touch the other buffer and never set a full flag.
- R12: `reg_rdata` holds the result of a read from the cycle after `reg_rd`. Words between the data area and the control word read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pingpong | input | 1 | 1: alternate buffers; 0: always buffer 0 |
| irq_master_en | input | 1 | Global interrupt enable |
| station_mac | input | 48 | Station address; bits [47:40] are compared with the first byte |
| rx_valid | input | 1 | Byte strobe |
| rx_first | input | 1 | Marks the first byte of a frame |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset inside the receive window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The filter is driven with four frame patterns:
- Group-addressed frames separate the bit-7 path from the address compare.
- Exactly matching unicast frames show that the compare accepts.
- Unicast frames with one flipped bit in one of the six address bytes show that every byte position is compared.
- Matching frames shorter than six bytes show that the decision waits for the whole address.

Frames sent into a full buffer, with alternation on and off, separate loss from rejection and show which buffer is used. An oversized frame and full-buffer comparisons of both data areas show that truncation and rejected frames never reach the other buffer.

// File: rtl/pprx_pkg.sv
package pprx_pkg;
   localparam int LANES        = 4;
   localparam int CTRL_FULL_B  = 0;
   localparam int CTRL_IEN_B   = 3;

   typedef enum logic [1:0] {RK_NONE, RK_DATA, RK_CTRL} rd_kind_e;

   typedef struct packed {
      logic ien;
      logic full;
   } ctrl_t;

   function automatic logic [31:0] ctrl_word(ctrl_t c);
      logic [31:0] w;
      w = '0;
      w[CTRL_FULL_B] = c.full;
      w[CTRL_IEN_B]  = c.ien;
      return w;
   endfunction
endpackage

// File: rtl/pprx_addr_filter.sv
module pprx_addr_filter #(
   parameter int MAC_BYTES = 6,
   parameter int CNT_W     = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   byte_vld,
   input  logic                   first,
   input  logic [CNT_W-1:0]       idx,
   input  logic [7:0]             data,
   input  logic [8*MAC_BYTES-1:0] station_mac,
   output logic                   accept_now
);
   logic       grp_q, match_q;
   logic       grp_now, match_now, in_addr;
   logic [7:0] exp_byte;

   always_comb begin
      exp_byte = '0;
      for (int k = 0; k < MAC_BYTES; k++) begin
         if (idx == CNT_W'(k)) exp_byte = station_mac[8*(MAC_BYTES-1-k) +: 8];
      end
      in_addr    = idx < CNT_W'(MAC_BYTES);
      grp_now    = first ? data[7] : grp_q;
      match_now  = (first ? 1'b1 : match_q) & (!in_addr | (data == exp_byte));
      accept_now = grp_now | (match_now & (idx >= CNT_W'(MAC_BYTES-1)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q   <= 1'b0;
         match_q <= 1'b0;
      end else if (byte_vld) begin
         grp_q   <= grp_now;
         match_q <= match_now;
      end
   end
endmodule

// File: rtl/pprx_frame_ctl.sv
module pprx_frame_ctl #(
   parameter int BUF_BYTES = 2036,
   parameter int CNT_W     = 12,
   parameter int WIDX_W    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_first,
   input  logic              rx_last,
   input  logic              sel_buf,
   input  logic              sel_full,
   input  logic              accept_now,
   output logic              byte_vld,
   output logic [CNT_W-1:0]  idx_now,
   output logic              wr_en,
   output logic              wr_buf,
   output logic [WIDX_W-1:0] wr_word,
   output logic [1:0]        wr_lane,
   output logic              commit,
   output logic              commit_buf
);
   logic             active_q, cur_q, lost_q;
   logic [CNT_W-1:0] cnt_q;
   logic             lost_now;

   always_comb begin
      byte_vld   = rx_valid & (rx_first | active_q);
      idx_now    = rx_first ? '0 : cnt_q;
      wr_buf     = rx_first ? sel_buf : cur_q;
      lost_now   = rx_first ? sel_full : lost_q;
      wr_en      = byte_vld & !lost_now & (idx_now < CNT_W'(BUF_BYTES));
      wr_word    = WIDX_W'(idx_now[CNT_W-1:2]);
      wr_lane    = idx_now[1:0];
      commit     = byte_vld & rx_last & !lost_now & accept_now;
      commit_buf = wr_buf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cur_q    <= 1'b0;
         lost_q   <= 1'b0;
         cnt_q    <= '0;
      end else if (byte_vld) begin
         active_q <= !rx_last;
         cur_q    <= wr_buf;
         lost_q   <= lost_now;
         cnt_q    <= (idx_now >= CNT_W'(BUF_BYTES)) ? idx_now : idx_now + 1'b1;
      end
   end
endmodule

// File: rtl/pprx_buf_mem.sv
module pprx_buf_mem #(
   parameter int WORDS  = 509,
   parameter int WIDX_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic              wbuf,
   input  logic [WIDX_W-1:0] widx,
   input  logic [1:0]        wlane,
   input  logic [7:0]        wdata,
   input  logic              re,
   input  logic              rbuf,
   input  logic [WIDX_W-1:0] ridx,
   output logic [31:0]       rdata
);
   localparam int DEPTH  = 2 * WORDS;
   localparam int MIDX_W = $clog2(DEPTH);

   logic [MIDX_W-1:0] wa, ra;
   assign wa = (wbuf ? MIDX_W'(WORDS) : '0) + MIDX_W'(widx);
   assign ra = (rbuf ? MIDX_W'(WORDS) : '0) + MIDX_W'(ridx);

   for (genvar l = 0; l < pprx_pkg::LANES; l++) begin : g_lane
      logic [7:0] arr [DEPTH];
      always_ff @(posedge clk) begin
         if (we && wlane == 2'(l)) arr[wa] <= wdata;
         if (re) rdata[8*l +: 8] <= arr[ra];
      end
   end
endmodule

// File: rtl/pingpong_rx_buffer.sv
module pingpong_rx_buffer #(
   parameter int BUF_BYTES = 2036,
   parameter int MAC_BYTES = 6,
   parameter int WIN_AW    = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_pingpong,
   input  logic                   irq_master_en,
   input  logic [8*MAC_BYTES-1:0] station_mac,
   input  logic                   rx_valid,
   input  logic                   rx_first,
   input  logic                   rx_last,
   input  logic [7:0]             rx_data,
   input  logic                   reg_wr,
   input  logic                   reg_rd,
   input  logic [WIN_AW-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   output logic                   rx_irq
);
   import pprx_pkg::*;

   localparam int WORDS      = (BUF_BYTES + 3) / 4;
   localparam int WIDX_W     = $clog2(WORDS);
   localparam int CNT_W      = $clog2(BUF_BYTES + 1);
   localparam int HALF_BYTES = 2 ** (WIN_AW - 1);
   localparam int HW_W       = WIN_AW - 3;
   localparam int CTRL_WORD  = HALF_BYTES / 4 - 1;

   if (BUF_BYTES > HALF_BYTES - 4) begin : g_bad_fit
      $error("BUF_BYTES does not fit below the control word");
   end
   if (BUF_BYTES < MAC_BYTES) begin : g_bad_min
      $error("BUF_BYTES smaller than the address field");
   end

   ctrl_t ctrl_q [2];
   logic  sel_q;
   logic  sel_buf, sel_full;

   logic              byte_vld, accept_now, wr_en, wr_buf, commit, commit_buf;
   logic [CNT_W-1:0]  idx_now;
   logic [WIDX_W-1:0] wr_word;
   logic [1:0]        wr_lane;

   logic [HW_W-1:0]   bus_word;
   logic              bus_buf, sw_hit, data_hit;
   logic [1:0]        full_vec;
   rd_kind_e          rd_kind_q;
   logic [31:0]       rd_ctrl_q, mem_rdata;
   logic              unused_bits;

   assign unused_bits = ^{reg_wdata[31:4], reg_wdata[2:1], reg_addr[1:0]};
   assign bus_word    = reg_addr[WIN_AW-2:2];
   assign bus_buf     = reg_addr[WIN_AW-1];
   assign sw_hit      = reg_wr && (int'(bus_word) == CTRL_WORD);
   assign data_hit    = int'(bus_word) < WORDS;
   assign sel_buf     = cfg_pingpong & sel_q;
   assign sel_full    = ctrl_q[sel_buf].full;
   assign full_vec    = {ctrl_q[1].full, ctrl_q[0].full};

   pprx_addr_filter #(.MAC_BYTES(MAC_BYTES), .CNT_W(CNT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .first(rx_first),
      .idx(idx_now), .data(rx_data), .station_mac(station_mac),
      .accept_now(accept_now));

   pprx_frame_ctl #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .WIDX_W(WIDX_W)) u_fctl (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
      .rx_last(rx_last), .sel_buf(sel_buf), .sel_full(sel_full),
      .accept_now(accept_now), .byte_vld(byte_vld), .idx_now(idx_now),
      .wr_en(wr_en), .wr_buf(wr_buf), .wr_word(wr_word), .wr_lane(wr_lane),
      .commit(commit), .commit_buf(commit_buf));

   pprx_buf_mem #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_mem (
      .clk(clk), .we(wr_en), .wbuf(wr_buf), .widx(wr_word), .wlane(wr_lane),
      .wdata(rx_data), .re(reg_rd && data_hit), .rbuf(bus_buf),
      .ridx(WIDX_W'(bus_word)), .rdata(mem_rdata));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) ctrl_q[b] <= '0;
         sel_q     <= 1'b0;
         rx_irq    <= 1'b0;
         rd_kind_q <= RK_NONE;
         rd_ctrl_q <= '0;
      end else begin
         if (sw_hit) begin
            ctrl_q[bus_buf].full <= reg_wdata[CTRL_FULL_B];
            ctrl_q[bus_buf].ien  <= reg_wdata[CTRL_IEN_B];
         end
         if (commit) begin
            ctrl_q[commit_buf].full <= 1'b1;
            sel_q <= cfg_pingpong ? !commit_buf : 1'b0;
         end
         rx_irq <= commit & ctrl_q[0].ien & irq_master_en;
         if (reg_rd) begin
            if (int'(bus_word) == CTRL_WORD) rd_kind_q <= RK_CTRL;
            else if (data_hit)              rd_kind_q <= RK_DATA;
            else                            rd_kind_q <= RK_NONE;
            rd_ctrl_q <= ctrl_word(ctrl_q[bus_buf]);
         end
      end
   end

   always_comb begin
      case (rd_kind_q)
         RK_CTRL: reg_rdata = rd_ctrl_q;
         RK_DATA: reg_rdata = mem_rdata;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pprx_checker.sv
module pprx_checker #(
   parameter int BUF_BYTES = 2036,
   parameter int CNT_W     = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_pingpong,
   input logic             irq_master_en,
   input logic             rx_irq,
   input logic             commit,
   input logic             commit_buf,
   input logic             sel_q,
   input logic [1:0]       full_vec,
   input logic             ien0,
   input logic             wr_en,
   input logic [CNT_W-1:0] idx_now,
   input logic             sw_hit,
   input logic             sw_buf,
   input logic             sw_full
);
   // R8: alternation follows the buffer just filled
   assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cfg_pingpong) |=> (sel_q == !$past(commit_buf)));

   assert_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !cfg_pingpong) |=> (sel_q == 1'b0));

   // R7: interrupt only when both enables were set
   assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(ien0 && irq_master_en && commit));

   // R10: no byte written past the data area
   assert_trunc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (idx_now < CNT_W'(BUF_BYTES)));

   // R5, R11: a full flag rises only from a stored frame or a software write
   for (genvar b = 0; b < 2; b++) begin : g_full
      assert_full_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(full_vec[b]) |->
            (($past(commit) && $past(commit_buf) == 1'(b)) ||
             ($past(sw_hit) && $past(sw_buf) == 1'(b) && $past(sw_full))));
   end
endmodule

bind pingpong_rx_buffer pprx_checker #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_pingpong(cfg_pingpong),
   .irq_master_en(irq_master_en), .rx_irq(rx_irq), .commit(commit),
   .commit_buf(commit_buf), .sel_q(sel_q), .full_vec(full_vec),
   .ien0(ctrl_q[0].ien), .wr_en(wr_en), .idx_now(idx_now),
   .sw_hit(sw_hit), .sw_buf(bus_buf), .sw_full(reg_wdata[0]));

// File: tb/sim_pingpong_rx_buffer.sv
`timescale 1ns/1ps
module sim_pingpong_rx_buffer;
   localparam int BB    = 2036;
   localparam int WDS   = (BB + 3) / 4;
   localparam logic [47:0] MAC = 48'h021A2B3C4D5E;

   logic        clk = 0, rst_n = 0;
   logic        cfg_pingpong = 1, irq_master_en = 1;
   logic        rx_valid = 0, rx_first = 0, rx_last = 0;
   logic [7:0]  rx_data = 0;
   logic        reg_wr = 0, reg_rd = 0;
   logic [11:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic        rx_irq;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   bit         m_full [2];
   bit         m_ien  [2];
   bit         m_sel;
   logic [7:0] exp_mem   [2][BB];
   bit         exp_known [2][BB];
   logic [7:0] fr [2100];

   always #2.5 clk = ~clk;

   pingpong_rx_buffer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_pingpong(cfg_pingpong),
      .irq_master_en(irq_master_en), .station_mac(MAC),
      .rx_valid(rx_valid), .rx_first(rx_first), .rx_last(rx_last),
      .rx_data(rx_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_irq(rx_irq));

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit frame_accept(int len);
      if (fr[0][7]) return 1;
      if (len < 6) return 0;
      for (int k = 0; k < 6; k++)
         if (fr[k] != MAC[8*(5-k) +: 8]) return 0;
      return 1;
   endfunction

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1; reg_addr = a;
      @(negedge clk); reg_rd = 0; d = reg_rdata;
   endtask

   task automatic wr_ctrl(int b, logic [31:0] v);
      @(negedge clk); reg_wr = 1; reg_addr = 12'(b * 12'h800 + 12'h7FC); reg_wdata = v;
      @(negedge clk); reg_wr = 0;
      m_full[b] = v[0];
      m_ien[b]  = v[3];
   endtask

   task automatic check_ctrl(int b, string req);
      logic [31:0] d, e;
      rd(12'(b * 12'h800 + 12'h7FC), d);
      e = {28'd0, m_ien[b], 2'b00, m_full[b]};
      check(d === e, req, d, e);
   endtask

   task automatic check_buf(int b, string req);
      logic [31:0] d;
      int bad = 0;
      logic [31:0] ba = 0, be = 0;
      for (int w = 0; w < WDS; w++) begin
         rd(12'(b * 12'h800 + w * 4), d);
         for (int l = 0; l < 4; l++) begin
            int i = w * 4 + l;
            if (i < BB && exp_known[b][i] && d[8*l +: 8] !== exp_mem[b][i]) begin
               if (bad == 0) begin ba = d; be = {24'd0, exp_mem[b][i]}; end
               bad++;
            end
         end
      end
      check(bad == 0, req, ba, be);
   endtask

   task automatic send_frame(int len, string req);
      int  cur;
      bit  lost, acc, eirq;
      cur  = cfg_pingpong ? int'(m_sel) : 0;
      lost = m_full[cur];
      acc  = frame_accept(len);
      eirq = !lost && acc && m_ien[0] && irq_master_en;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_first = (i == 0); rx_last = (i == len - 1); rx_data = fr[i];
      end
      @(negedge clk);
      check(rx_irq === eirq, req, {31'd0, rx_irq}, {31'd0, eirq});
      rx_valid = 0; rx_first = 0; rx_last = 0;
      if (!lost) begin
         for (int i = 0; i < len && i < BB; i++) begin
            exp_mem[cur][i] = fr[i];
            exp_known[cur][i] = 1;
         end
         if (acc) begin
            m_full[cur] = 1;
            m_sel = cfg_pingpong ? !cur[0] : 1'b0;
         end
      end
   endtask

   task automatic build(int len, int kind);
      for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
      if (kind == 0) fr[0][7] = 1'b1;
      else begin
         for (int k = 0; k < 6 && k < len; k++) fr[k] = MAC[8*(5-k) +: 8];
         if (kind == 2) begin
            int k = $urandom % 6;
            fr[k] = fr[k] ^ (8'h01 << ($urandom % 7));
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(rx_irq === 1'b0, "R1 irq after reset", {31'd0, rx_irq}, 0);
      check_ctrl(0, "R1 ctrl0 reset");
      check_ctrl(1, "R1 ctrl1 reset");

      wr_ctrl(0, 32'hFFFF_FFF8);
      check_ctrl(0, "R9 only bits 0 and 3 kept");

      build(20, 1); send_frame(20, "R3 R7 matching unicast irq");
      check_ctrl(0, "R1 R5 first frame to buffer 0");
      check_buf(0, "R4 buffer 0 contents");

      build(33, 0); send_frame(33, "R2 R7 group frame into buffer 1 gated by ctrl0");
      check_ctrl(1, "R5 R8 buffer 1 full after toggle");
      check_buf(1, "R4 buffer 1 contents");

      build(40, 0); send_frame(40, "R6 lost frame no irq");
      check_ctrl(0, "R6 ctrl0 unchanged");
      check_ctrl(1, "R6 ctrl1 unchanged");
      check_buf(0, "R6 buffer 0 not overwritten");

      wr_ctrl(0, 32'h8);
      check_ctrl(0, "R9 release buffer 0");
      build(30, 2); send_frame(30, "R3 mismatched unicast no irq");
      check_ctrl(0, "R3 R11 rejected frame leaves full clear");
      check_buf(1, "R11 other buffer untouched");
      build(4, 3); send_frame(4, "R3 short unicast rejected");
      check_ctrl(0, "R3 short frame leaves full clear");

      irq_master_en = 0;
      build(12, 1); send_frame(12, "R7 master enable off");
      check_ctrl(0, "R5 full set without irq");
      irq_master_en = 1;

      cfg_pingpong = 0;
      wr_ctrl(0, 32'h8); wr_ctrl(1, 32'h0);
      build(10, 0); send_frame(10, "R8 fixed mode first");
      wr_ctrl(0, 32'h8);
      build(10, 0); send_frame(10, "R8 fixed mode second");
      check_ctrl(1, "R8 buffer 1 unused in fixed mode");
      check_ctrl(0, "R8 buffer 0 used in fixed mode");
      wr_ctrl(0, 32'h8);

      build(2040, 0); send_frame(2040, "R10 oversized frame irq");
      check_ctrl(0, "R10 oversized frame marked full");
      check_buf(0, "R10 truncated contents");
      check_buf(1, "R10 no spill into buffer 1");
      rd(12'h7F8, d);
      check(d === 32'h0, "R12 gap word reads zero", d, 0);
      cfg_pingpong = 1;

      for (int n = 0; n < 40; n++) begin
         int kind = $urandom % 4;
         int len  = (kind == 3) ? 1 + $urandom % 5 : 6 + $urandom % 59;
         if ($urandom % 2) wr_ctrl($urandom % 2, {28'd0, 1'($urandom), 3'b000});
         irq_master_en = ($urandom % 4) != 0;
         build(len, kind);
         send_frame(len, "R2 R3 R6 R7 random frame irq");
         if (n % 8 == 7) begin
            check_ctrl(0, "R5 R9 random ctrl0");
            check_ctrl(1, "R5 R9 random ctrl1");
         end
      end
      check_buf(0, "R4 R11 random buffer 0");
      check_buf(1, "R4 R11 random buffer 1");

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule